// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This block takes one single-precision IEEE-754 operand and produces the nearest integral value in the same format, using one of five rounding directions. Along with the result it reports three exception flags: invalid operation (for a signaling NaN), inexact (only in the exact variant, and only when the value changed) and input denormal (when a subnormal operand is flushed). Control inputs choose the rounding direction, the exact variant, default-NaN substitution and flush-to-zero handling of subnormal operands.

Each operand presented with `in_valid` is registered once. Its result and flags appear on the outputs in the following cycle, together with `out_valid`. The outputs hold their value while no new operand arrives. A small combinational decoder sits beside the datapath. It turns an instruction's 4-bit function code and 2-bit element-size field into a rounding direction, an exact-variant bit and a legality flag.

Top module: `rndint_unit`

## Requirements
- R1: The decoder maps function code 0x8 to direction 0 (ties to even, not exact), 0x9 to direction 0 exact, 0xA to direction 4 (ties away), 0xB to direction 3 (toward zero), 0xD to direction 2 (toward minus infinity) and 0xF to direction 1 (toward plus infinity). For any other code, and for any illegal size, it drives direction 0 and exact 0.
- R2: `dec_legal` is 1 only for one of the six codes above together with size 0b10 (single) or 0b01 (half). Sizes 0b00 and 0b11 are always illegal.
- R3: For operands with biased exponent 127 to 149, directions 0 to 3 give the correctly rounded integral value: ties to even (0), toward plus infinity (1), toward minus infinity (2) and toward zero (3). Direction codes 5 to 7 behave as toward zero.
- R4: Direction 4 rounds a fraction of exactly one half away from zero (2.5 gives 3.0, -2.5 gives -3.0), and rounds other fractions to nearest.
- R5: `out_inexact` is 1 only when `in_exact` is 1 and the result differs from the operand.
- R6: A nonzero finite operand of magnitude below 1.0 gives ±0.0 or ±1.0 with the operand's sign. Ties to even gives 1.0 only above one half. Ties away gives 1.0 at one half or above. Toward plus infinity gives +1.0 for positive operands, and toward minus infinity gives -1.0 for negative ones.
- R7: Infinities, zeros and operands with biased exponent 150 or more pass through unchanged with all flags clear.
- R8: A signaling NaN (exponent all ones, fraction bit 22 clear, fraction nonzero) raises `out_invalid`. A quiet NaN raises no flag.
- R9: A quiet NaN, or any NaN while `in_dnan` is 1, yields 0x7FC00000. A signaling NaN with `in_dnan` at 0 yields the operand with bit 22 set.
- R10: With `in_ftz` at 1, a subnormal operand yields a zero carrying the operand's sign and raises `out_denorm`. With `in_ftz` at 0 it rounds like any value below one (R6), and `out_denorm` stays 0.
- R11: Every zero result carries the sign bit of the operand (-0.3 rounded toward zero or toward plus infinity gives 0x80000000).
- R12: `out_valid` is 0 in reset and equals the previous cycle's `in_valid`. Results appear one cycle after capture and hold while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 32 | Single-precision operand |
| in_mode | input | 3 | Rounding direction (0 even, 1 up, 2 down, 3 zero, 4 away) |
| in_exact | input | 1 | Exact variant: enables the inexact flag |
| in_dnan | input | 1 | Replace every NaN result by the default quiet NaN |
| in_ftz | input | 1 | Flush subnormal operands to zero |
| out_valid | output | 1 | Result present |
| out_res | output | 32 | Rounded single-precision result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Input-denormal flag |
| dec_func | input | 4 | Instruction function code |
| dec_size | input | 2 | Instruction element-size field |
| dec_mode | output | 3 | Decoded rounding direction |
| dec_exact | output | 1 | Decoded exact variant |
| dec_legal | output | 1 | Encoding is legal |

## Verification
The hardest cases to reach are ties and carries: an exact half at each possible binary-point position, and rounding that carries out of the significand into the next power of two (for example 8388607.5 rounding up). Uniformly random words almost never land there. Half the random operands therefore have their exponent forced into the band just below and above the integral threshold, and directed operands hit 0.5, 1.5, 2.5, the largest fractional value and 1.0 minus one ulp. All of these run in every direction and in every combination of the three flags.

// File: rtl/rndint_pkg.sv
package rndint_pkg;

  typedef enum logic [2:0] {
    RD_EVEN = 3'd0,
    RD_UP   = 3'd1,
    RD_DOWN = 3'd2,
    RD_ZERO = 3'd3,
    RD_AWAY = 3'd4
  } rdir_e;

  // Decide whether the truncated magnitude is incremented.
  function automatic logic round_inc(input logic [2:0] dir, input logic sgn,
                                     input logic lsb, input logic gt_half,
                                     input logic eq_half, input logic nz);
    logic inc;
    case (dir)
      RD_EVEN: inc = gt_half | (eq_half & lsb);
      RD_AWAY: inc = gt_half | eq_half;
      RD_UP:   inc = nz & ~sgn;
      RD_DOWN: inc = nz & sgn;
      default: inc = 1'b0;
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/rndint_decode.sv
module rndint_decode
  import rndint_pkg::*;
(
  input  logic [3:0] func,
  input  logic [1:0] size,
  output logic [2:0] mode,
  output logic       exact,
  output logic       legal
);

  logic       func_ok;
  logic       size_ok;
  logic [2:0] mode_raw;
  logic       exact_raw;

  always_comb begin
    func_ok   = 1'b1;
    exact_raw = 1'b0;
    mode_raw  = RD_EVEN;
    case (func)
      4'h8: mode_raw = RD_EVEN;
      4'h9: begin mode_raw = RD_EVEN; exact_raw = 1'b1; end
      4'hA: mode_raw = RD_AWAY;
      4'hB: mode_raw = RD_ZERO;
      4'hD: mode_raw = RD_DOWN;
      4'hF: mode_raw = RD_UP;
      default: func_ok = 1'b0;
    endcase
    size_ok = (size == 2'b10) || (size == 2'b01);
    legal   = func_ok & size_ok;
    mode    = legal ? mode_raw : 3'd0;
    exact   = legal & exact_raw;
  end

endmodule

// File: rtl/rndint_core.sv
module rndint_core
  import rndint_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op,
  input  logic [2:0]           dir,
  input  logic                 exact,
  input  logic                 dnan,
  input  logic                 ftz,
  output logic [EXP_W+MAN_W:0] res,
  output logic                 flag_inv,
  output logic                 flag_inx,
  output logic                 flag_den
);

  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int INT_E = BIAS + MAN_W;
  localparam int SIG_W = MAN_W + 1;
  localparam int SH_W  = $clog2(MAN_W + 1);
  localparam logic [W-1:0] QNAN_DEF = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [EXP_W-1:0] E_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] E_HALF = EXP_W'(BIAS - 1);
  localparam logic [EXP_W:0]   E_INT  = (EXP_W+1)'(INT_E);

  logic                 sgn;
  logic [EXP_W-1:0]     ex;
  logic [MAN_W-1:0]     fr;
  logic [EXP_W:0]       sh_full;
  logic [SH_W-1:0]      sh;
  logic [SIG_W:0]       mant;
  logic [SIG_W:0]       mask;
  logic [SIG_W:0]       unit;
  logic [SIG_W:0]       rem;
  logic [SIG_W:0]       halfv;
  logic [SIG_W:0]       sum;
  logic                 inc_mid;
  logic                 inc_tiny;
  logic                 tiny_gt;
  logic                 tiny_eq;

  assign sgn = op[W-1];
  assign ex  = op[W-2:MAN_W];
  assign fr  = op[MAN_W-1:0];

  // Partial-integer path: operand has 1..MAN_W fractional bits.
  always_comb begin
    sh_full = E_INT - {1'b0, ex};
    sh      = sh_full[SH_W-1:0];
    mant    = {1'b0, 1'b1, fr};
    unit    = (SIG_W+1)'(1) << sh;
    mask    = unit - (SIG_W+1)'(1);
    rem     = mant & mask;
    halfv   = mask ^ (mask >> 1);
    inc_mid = round_inc(dir, sgn, |(mant & unit), rem > halfv,
                        rem == halfv, |rem);
    sum     = (mant & ~mask) + (inc_mid ? unit : '0);
  end

  // Below-one path: integer part is zero (even).
  always_comb begin
    tiny_gt  = (ex == E_HALF) && (fr != '0);
    tiny_eq  = (ex == E_HALF) && (fr == '0);
    inc_tiny = round_inc(dir, sgn, 1'b0, tiny_gt, tiny_eq, 1'b1);
  end

  always_comb begin
    res      = op;
    flag_inv = 1'b0;
    flag_inx = 1'b0;
    flag_den = 1'b0;
    if (ex == '1) begin
      if (fr != '0) begin
        flag_inv = ~fr[MAN_W-1];
        if (dnan || fr[MAN_W-1]) res = QNAN_DEF;
        else                     res = op | (W'(1) << (MAN_W - 1));
      end
    end else if (ex == '0) begin
      if (fr != '0) begin
        if (ftz) begin
          res      = {sgn, {(W-1){1'b0}}};
          flag_den = 1'b1;
        end else begin
          res      = inc_tiny ? {sgn, E_ONE, {MAN_W{1'b0}}} : {sgn, {(W-1){1'b0}}};
          flag_inx = exact;
        end
      end
    end else if ({1'b0, ex} >= E_INT) begin
      res = op;
    end else if (ex < E_ONE) begin
      res      = inc_tiny ? {sgn, E_ONE, {MAN_W{1'b0}}} : {sgn, {(W-1){1'b0}}};
      flag_inx = exact;
    end else begin
      if (sum[SIG_W]) res = {sgn, ex + EXP_W'(1), {MAN_W{1'b0}}};
      else            res = {sgn, ex, sum[MAN_W-1:0]};
      flag_inx = exact & (|rem);
    end
  end

endmodule

// File: rtl/rndint_unit.sv
module rndint_unit
  import rndint_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] in_op,
  input  logic [2:0]           in_mode,
  input  logic                 in_exact,
  input  logic                 in_dnan,
  input  logic                 in_ftz,
  output logic                 out_valid,
  output logic [EXP_W+MAN_W:0] out_res,
  output logic                 out_invalid,
  output logic                 out_inexact,
  output logic                 out_denorm,
  input  logic [3:0]           dec_func,
  input  logic [1:0]           dec_size,
  output logic [2:0]           dec_mode,
  output logic                 dec_exact,
  output logic                 dec_legal
);

  localparam int W = 1 + EXP_W + MAN_W;

  logic [W-1:0] c_res;
  logic         c_inv;
  logic         c_inx;
  logic         c_den;

  logic [W-1:0] res_q, res_d;
  logic         inv_q, inv_d;
  logic         inx_q, inx_d;
  logic         den_q, den_d;
  logic         vld_q, vld_d;

  rndint_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_core (
    .op       (in_op),
    .dir      (in_mode),
    .exact    (in_exact),
    .dnan     (in_dnan),
    .ftz      (in_ftz),
    .res      (c_res),
    .flag_inv (c_inv),
    .flag_inx (c_inx),
    .flag_den (c_den)
  );

  rndint_decode u_dec (
    .func  (dec_func),
    .size  (dec_size),
    .mode  (dec_mode),
    .exact (dec_exact),
    .legal (dec_legal)
  );

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    inv_d = inv_q;
    inx_d = inx_q;
    den_d = den_q;
    if (in_valid) begin
      res_d = c_res;
      inv_d = c_inv;
      inx_d = c_inx;
      den_d = c_den;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
      inx_q <= 1'b0;
      den_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      inv_q <= inv_d;
      inx_q <= inx_d;
      den_q <= den_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_res     = res_q;
  assign out_invalid = inv_q;
  assign out_inexact = inx_q;
  assign out_denorm  = den_q;

endmodule

// File: rtl/rndint_chk.sv
module rndint_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [EXP_W+MAN_W:0] in_op,
  input logic                 in_exact,
  input logic                 in_ftz,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] out_res,
  input logic                 out_invalid,
  input logic                 out_inexact,
  input logic                 out_denorm,
  input logic [1:0]           dec_size,
  input logic                 dec_legal
);

  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int INT_E = (1 << (EXP_W - 1)) - 1 + MAN_W;

  logic op_snan;
  logic op_big;
  assign op_snan = (in_op[W-2:MAN_W] == '1) && !in_op[MAN_W-1] && (in_op[MAN_W-2:0] != '0);
  assign op_big  = (int'(in_op[W-2:MAN_W]) >= INT_E) && (in_op[W-2:MAN_W] != '1);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R12
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_res)); // R12
  AST_INEXACT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_exact) |=> !out_inexact); // R5
  AST_DENORM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ftz) |=> !out_denorm); // R10
  AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_snan) |=> out_invalid); // R8
  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_res[W-2:0] != '0) || (out_res[W-1] == $past(in_op[W-1])))); // R11
  AST_BIG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_big) |=> (out_res == $past(in_op) && !out_inexact)); // R7
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_legal |-> (dec_size == 2'b10 || dec_size == 2'b01)); // R2

endmodule

bind rndint_unit rndint_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_op       (in_op),
  .in_exact    (in_exact),
  .in_ftz      (in_ftz),
  .out_valid   (out_valid),
  .out_res     (out_res),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact),
  .out_denorm  (out_denorm),
  .dec_size    (dec_size),
  .dec_legal   (dec_legal)
);

// File: tb/tb_rndint_unit.sv
module tb_rndint_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_op;
  logic [2:0]  in_mode;
  logic        in_exact, in_dnan, in_ftz;
  logic        out_valid;
  logic [31:0] out_res;
  logic        out_invalid, out_inexact, out_denorm;
  logic [3:0]  dec_func;
  logic [1:0]  dec_size;
  logic [2:0]  dec_mode;
  logic        dec_exact, dec_legal;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rndint_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_mode(in_mode), .in_exact(in_exact), .in_dnan(in_dnan), .in_ftz(in_ftz),
    .out_valid(out_valid), .out_res(out_res), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_denorm(out_denorm),
    .dec_func(dec_func), .dec_size(dec_size), .dec_mode(dec_mode),
    .dec_exact(dec_exact), .dec_legal(dec_legal)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] int_to_fp(input bit s, input longint unsigned n);
    int p;
    logic [63:0] m;
    if (n == 0) return {s, 31'b0};
    p = 0;
    for (int i = 0; i < 26; i++) if (n[i]) p = i;
    m = (p <= 23) ? (n << (23 - p)) : (n >> (p - 23));
    return {s, 8'(127 + p), m[22:0]};
  endfunction

  // Arithmetic reference: value scaled by 2^40 in a 64-bit word.
  task automatic model(input logic [31:0] op, input logic [2:0] m, input bit ex,
                       input bit dn, input bit fz, output logic [31:0] r,
                       output bit inv, output bit inx, output bit den, output string tag);
    bit s;
    int e;
    logic [22:0] f;
    longint unsigned v, q, rm, h;
    bit up;
    s = op[31]; e = int'(op[30:23]); f = op[22:0];
    inv = 0; inx = 0; den = 0; r = op; tag = "R3";
    if (e == 255) begin
      if (f != 0) begin
        inv = !f[22];
        r = (dn || f[22]) ? 32'h7FC00000 : (op | 32'h00400000);
        tag = inv ? "R8" : "R9";
      end else tag = "R7";
      return;
    end
    if (e == 0 && f == 0) begin tag = "R11"; return; end
    if (e == 0 && fz) begin r = {s, 31'b0}; den = 1; tag = "R10"; return; end
    if (e >= 150) begin tag = "R7"; return; end
    h = 64'd1 << 39;
    if (e < 110) begin q = 0; rm = 1; end
    else begin
      v = {40'd0, 1'b1, f} << (e - 110);
      q = v >> 40;
      rm = v & ((64'd1 << 40) - 1);
    end
    case (m)
      3'd0: up = (rm > h) || (rm == h && q[0]);
      3'd1: up = (rm != 0) && !s;
      3'd2: up = (rm != 0) && s;
      3'd4: up = (rm >= h);
      default: up = 0;
    endcase
    r = int_to_fp(s, q + longint'(up));
    inx = ex && (rm != 0);
    if (e == 0) tag = "R10";
    else if (e < 127) tag = "R6";
    else if (m == 3'd4) tag = "R4";
    if (inx) tag = "R5";
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic run_op(input logic [31:0] op, input logic [2:0] m, input bit ex,
                        input bit dn, input bit fz);
    logic [31:0] r;
    bit inv, inx, den;
    string tag;
    in_valid = 1'b1; in_op = op; in_mode = m;
    in_exact = ex; in_dnan = dn; in_ftz = fz;
    model(op, m, ex, dn, fz, r, inv, inx, den, tag);
    @(negedge clk);
    check(tag, {28'd0, out_valid, out_res, out_invalid, out_inexact, out_denorm},
               {28'd0, 1'b1, r, inv, inx, den});
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R12 actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] dir_ops [16];
    logic [31:0] held;
    dir_ops = '{32'h3F000000, 32'h3FC00000, 32'h40200000, 32'h3E99999A,
                32'h00000000, 32'h7F7FFFFF, 32'h7F800000, 32'h7F800001,
                32'h7FC12345, 32'h00000001, 32'h007FFFFF, 32'h3F800000,
                32'h4AFFFFFF, 32'h3F400000, 32'h3F7FFFFF, 32'h4B000001};
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_mode = '0;
    in_exact = 0; in_dnan = 0; in_ftz = 0; dec_func = '0; dec_size = '0;
    @(negedge clk);
    check("R12 reset", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle", {63'd0, out_valid}, 64'd0);

    // Decoder sweep: R1 and R2.
    for (int fc = 0; fc < 16; fc++) begin
      for (int sz = 0; sz < 4; sz++) begin
        bit fok, lg, ex;
        logic [2:0] md;
        dec_func = 4'(fc); dec_size = 2'(sz);
        fok = 1; ex = 0; md = 0;
        case (fc)
          8: md = 0;
          9: begin md = 0; ex = 1; end
          10: md = 4;
          11: md = 3;
          13: md = 2;
          15: md = 1;
          default: fok = 0;
        endcase
        lg = fok && (sz == 1 || sz == 2);
        if (!lg) begin md = 0; ex = 0; end
        #1;
        check("R2 legal", {63'd0, dec_legal}, {63'd0, lg});
        check("R1 map", {60'd0, dec_mode, dec_exact}, {60'd0, md, ex});
      end
    end

    // Directed corners in every direction and flag combination.
    @(negedge clk);
    for (int i = 0; i < 16; i++)
      for (int sg = 0; sg < 2; sg++)
        for (int m = 0; m < 5; m++)
          for (int fl = 0; fl < 8; fl++)
            run_op({1'(sg), dir_ops[i][30:0]}, 3'(m), fl[0], fl[1], fl[2]);

    // Explicit examples.
    run_op(32'hC0200000, 3'd4, 0, 0, 0);  // R4: -2.5 -> -3.0
    check("R4 neg tie", {32'd0, out_res}, {32'd0, 32'hC0400000});
    run_op(32'hBE99999A, 3'd1, 0, 0, 0);  // R11: -0.3 up -> -0.0
    check("R11 neg zero", {32'd0, out_res}, {32'd0, 32'h80000000});

    // Random operands, half of them near the integral threshold.
    for (int k = 0; k < 10000; k++) begin
      logic [31:0] op;
      op = $urandom;
      if ($urandom % 2 == 0) op[30:23] = 8'(105 + ($urandom % 50));
      run_op(op, 3'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // Hold while idle: R12.
    held = out_res;
    in_valid = 1'b0; in_op = 32'h40200000;
    @(negedge clk);
    check("R12 hold valid", {63'd0, out_valid}, 64'd0);
    check("R12 hold data", {32'd0, out_res}, {32'd0, held});

    finish_run();
  end

endmodule